// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block sits between a host and a battery-backed byte-wide static memory and decides, cycle by cycle, whether the host may touch that memory. It watches three digitized supply-level flags from external comparators. The flags say whether the supply is above the full-operation level, above the write-protect trip level, and above the battery switchover level. They arrive already synchronized and debounced. From these flags the block gates the host's chip-enable and write-enable, forces the memory data outputs to high impedance, selects the battery as the array's source when the supply collapses, and keeps a one-time arming latch for the battery path.

A memory shipped with its battery disconnected stays in a sealed condition until the supply first crosses the trip level. From then on the battery path is armed permanently, and only a power-on reset clears it. Once power has returned, access is held off until a parameterized number of timebase ticks has elapsed. The count runs only while the supply stays above the full-operation level and the host keeps chip-enable inactive. If the supply dips below the trip level during that wait, the block falls back to its protected state.

Top module: `pfs_supervisor`

## Requirements
- R1: `bat_en` is 0 after `por` and becomes 1 at the first clock edge that samples `lvl_trip`=1. From then on it stays 1 through `rst` and through any flag pattern, until the next `por`.
- R2: In the sealed state (`state_code`=0), `bat_sel` is 0 and no access is granted, whatever `lvl_swo` and the host inputs do. The block leaves the sealed state only at an edge that samples `lvl_trip`=1, and it then enters recovery.
- R3: Whenever `lvl_trip` is 0, `mem_ce_n`, `mem_we_n` and `out_hiz` are all 1 in that same cycle, whatever the host inputs and the state.
- R4: `bat_sel` is 1 exactly in the backup state (`state_code`=2). The protected state moves to backup at an edge that samples `lvl_swo`=0, and backup returns to protected at an edge that samples `lvl_swo`=1.
- R5: From the granted state (code 4) or recovery (code 3), an edge that samples `lvl_trip`=0 moves the block to backup if `lvl_swo` is also 0, and to protected (code 1) otherwise.
- R6: From the protected state, an edge that samples `lvl_swo`=1 and `lvl_trip`=1 moves the block to recovery, with the hold-off count starting from zero.
- R7: In recovery, the hold-off count advances at each edge that samples `tick`=1, `lvl_run`=1 and `host_ce_n`=1. It restarts from zero at any edge that samples `lvl_run`=0 or `host_ce_n`=0. After HOLD_TICKS advances, the next edge enters the granted state.
- R8: In the granted state with `lvl_trip`=1, the gating works as follows: `mem_ce_n` follows `host_ce_n`; `mem_we_n` = `host_we_n` OR `host_ce_n`; `out_hiz` is 0 only when `host_ce_n`=0, `host_oe_n`=0 and `host_we_n`=1. An active write therefore forces high impedance.
- R9: `state_code` encodes sealed=0, protected=1, backup=2, recovery=3, granted=4. `por` forces sealed. A synchronous `rst` forces protected if `bat_en` is 1, and sealed otherwise. Outside the granted state, the memory strobes are held at 1 and `out_hiz` is 1.
- R10: `acc_grant` is 1 exactly when the state is granted and `lvl_trip` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high functional reset (does not clear the arming latch) |
| por | input | 1 | Power-on reset; clears the arming latch and forces the sealed state |
| lvl_run | input | 1 | Supply above the full-operation level |
| lvl_trip | input | 1 | Supply above the write-protect trip level |
| lvl_swo | input | 1 | Supply above the battery switchover level |
| tick | input | 1 | Coarse timebase pulse for the hold-off count |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| mem_ce_n | output | 1 | Gated chip enable to the memory |
| mem_we_n | output | 1 | Gated write enable to the memory |
| out_hiz | output | 1 | Forces the memory data drivers to high impedance |
| bat_sel | output | 1 | Battery feeds the array |
| bat_en | output | 1 | Battery path armed (one-time latch) |
| acc_grant | output | 1 | Host access currently granted |
| state_code | output | 3 | Supervisor state code |

## Verification
The supervisor is driven through several supply-flag sequences, each of which separates one pair of behaviours:
- A cold first power-up, with the supply parked between switchover and trip, shows whether the sealed state really ignores the switchover flag.
- A brown-out that stops above switchover, set against a full loss that drops all three flags in one cycle, tells the protected path apart from the backup path.
- Recovery is tried with a trip glitch, with a dip below the full-operation level only, with a host chip-enable pulse and with sparse ticks. This separates a count restart from a count hold and from a state fall-back.
- Functional reset and power-on reset are applied once the battery path is armed, which shows whether each one clears the arming latch.

A reference model in the bench predicts every output on every cycle, and each mismatch is tagged with the requirement whose rule produced the expected value.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [2:0] {
        ST_SEALED = 3'd0,
        ST_GUARD  = 3'd1,
        ST_BATT   = 3'd2,
        ST_SETTLE = 3'd3,
        ST_LIVE   = 3'd4
    } pfs_state_e;

    typedef struct packed {
        logic run;
        logic trip;
        logic swo;
    } pfs_lvl_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } pfs_host_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic hiz;
    } pfs_gate_t;

    localparam pfs_gate_t GATE_SHUT = '{ce_n: 1'b1, we_n: 1'b1, hiz: 1'b1};

    // Where a loss of the trip flag lands, given the switchover flag.
    function automatic pfs_state_e pfs_drop_target(input logic swo);
        return swo ? ST_GUARD : ST_BATT;
    endfunction

    // A read drives the bus only with CE and OE active and no write pending.
    function automatic logic pfs_drives_bus(input pfs_host_t h);
        return !h.ce_n && !h.oe_n && h.we_n;
    endfunction

endpackage

// File: rtl/pfs_seal_latch.sv
module pfs_seal_latch (
    input  logic clk,
    input  logic por,
    input  logic trip,
    output logic armed
);
    // Cleared only by power-on reset; the functional reset has no path here.
    always_ff @(posedge clk) begin
        if (por)
            armed <= 1'b0;
        else if (trip)
            armed <= 1'b1;
    end
endmodule

// File: rtl/pfs_holdoff.sv
module pfs_holdoff #(
    parameter int unsigned HOLD_TICKS = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic done
);
    localparam int unsigned CW = (HOLD_TICKS < 2) ? 1 : $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_TICKS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (step && (cnt != LIMIT))
            cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIMIT);
endmodule

// File: rtl/pfs_fsm.sv
module pfs_fsm
    import pfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       por,
    input  logic       armed,
    input  logic       trip,
    input  logic       swo,
    input  logic       done,
    output pfs_state_e state
);
    pfs_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_SEALED: if (trip) nxt = ST_SETTLE;
            ST_GUARD: begin
                if (!swo)      nxt = ST_BATT;
                else if (trip) nxt = ST_SETTLE;
            end
            ST_BATT:   if (swo) nxt = ST_GUARD;
            ST_SETTLE: begin
                if (!trip)     nxt = pfs_drop_target(swo);
                else if (done) nxt = ST_LIVE;
            end
            ST_LIVE:   if (!trip) nxt = pfs_drop_target(swo);
            default:   nxt = ST_GUARD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (por)
            state <= ST_SEALED;
        else if (rst)
            state <= armed ? ST_GUARD : ST_SEALED;
        else
            state <= nxt;
    end
endmodule

// File: rtl/pfs_gate.sv
module pfs_gate
    import pfs_pkg::*;
(
    input  pfs_state_e state,
    input  logic       trip,
    input  pfs_host_t  host,
    output pfs_gate_t  gate,
    output logic       grant,
    output logic       bat_sel
);
    // The trip flag is used directly so protection needs no clock edge.
    assign grant   = (state == ST_LIVE) && trip;
    assign bat_sel = (state == ST_BATT);

    always_comb begin
        gate = GATE_SHUT;
        if (grant) begin
            gate.ce_n = host.ce_n;
            gate.we_n = host.we_n | host.ce_n;
            gate.hiz  = !pfs_drives_bus(host);
        end
    end
endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor
    import pfs_pkg::*;
#(
    parameter int unsigned HOLD_TICKS = 125
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       por,
    input  logic       lvl_run,
    input  logic       lvl_trip,
    input  logic       lvl_swo,
    input  logic       tick,
    input  logic       host_ce_n,
    input  logic       host_we_n,
    input  logic       host_oe_n,
    output logic       mem_ce_n,
    output logic       mem_we_n,
    output logic       out_hiz,
    output logic       bat_sel,
    output logic       bat_en,
    output logic       acc_grant,
    output logic [2:0] state_code
);
    pfs_lvl_t   lvl;
    pfs_host_t  host;
    pfs_gate_t  gate;
    pfs_state_e state;
    logic       armed;
    logic       hold_done;
    logic       hold_step;
    logic       hold_clr;

    assign lvl  = '{run: lvl_run, trip: lvl_trip, swo: lvl_swo};
    assign host = '{ce_n: host_ce_n, we_n: host_we_n, oe_n: host_oe_n};

    assign hold_step = tick & lvl.run & host.ce_n;
    assign hold_clr  = (state != ST_SETTLE) | !lvl.run | !host.ce_n;

    pfs_seal_latch u_seal (
        .clk   (clk),
        .por   (por),
        .trip  (lvl.trip),
        .armed (armed)
    );

    pfs_holdoff #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk  (clk),
        .rst  (rst | por),
        .clr  (hold_clr),
        .step (hold_step),
        .done (hold_done)
    );

    pfs_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .por   (por),
        .armed (armed),
        .trip  (lvl.trip),
        .swo   (lvl.swo),
        .done  (hold_done),
        .state (state)
    );

    pfs_gate u_gate (
        .state   (state),
        .trip    (lvl.trip),
        .host    (host),
        .gate    (gate),
        .grant   (acc_grant),
        .bat_sel (bat_sel)
    );

    assign mem_ce_n   = gate.ce_n;
    assign mem_we_n   = gate.we_n;
    assign out_hiz    = gate.hiz;
    assign bat_en     = armed;
    assign state_code = state;
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker (
    input logic       clk,
    input logic       rst,
    input logic       por,
    input logic       lvl_trip,
    input logic       lvl_swo,
    input logic       mem_ce_n,
    input logic       mem_we_n,
    input logic       out_hiz,
    input logic       bat_sel,
    input logic       bat_en,
    input logic       acc_grant,
    input logic [2:0] state_code
);
    p_trip_shuts_r3: assert property (@(posedge clk) disable iff (rst || por)
        !lvl_trip |-> (mem_ce_n && mem_we_n && out_hiz));

    p_seal_sticky_r1: assert property (@(posedge clk) disable iff (por)
        bat_en |=> bat_en);

    p_sealed_quiet_r2: assert property (@(posedge clk) disable iff (rst || por)
        (state_code == 3'd0) |-> (!bat_sel && !acc_grant && !bat_en));

    p_guard_to_batt_r4: assert property (@(posedge clk) disable iff (rst || por)
        (state_code == 3'd1 && !lvl_swo) |=> bat_sel);

    p_live_drop_r5: assert property (@(posedge clk) disable iff (rst || por)
        (state_code == 3'd4 && !lvl_trip) |=> (state_code == 3'd1 || state_code == 3'd2));

    p_settle_no_grant_r7: assert property (@(posedge clk) disable iff (rst || por)
        (state_code == 3'd3 && !lvl_trip) |=> (state_code != 3'd4));

    p_grant_needs_live_r10: assert property (@(posedge clk) disable iff (rst || por)
        acc_grant |-> (state_code == 3'd4 && lvl_trip));

    p_shut_outside_live_r9: assert property (@(posedge clk) disable iff (rst || por)
        (state_code != 3'd4) |-> (mem_ce_n && mem_we_n && out_hiz));
endmodule

bind pfs_supervisor pfs_checker u_pfs_checker (
    .clk        (clk),
    .rst        (rst),
    .por        (por),
    .lvl_trip   (lvl_trip),
    .lvl_swo    (lvl_swo),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .out_hiz    (out_hiz),
    .bat_sel    (bat_sel),
    .bat_en     (bat_en),
    .acc_grant  (acc_grant),
    .state_code (state_code)
);

// File: tb/tb_pfs_supervisor.sv
module tb_pfs_supervisor;
    localparam int unsigned HOLD = 5;

    logic clk = 1'b0;
    logic rst, por, lvl_run, lvl_trip, lvl_swo, tick, host_ce_n, host_we_n, host_oe_n;
    logic mem_ce_n, mem_we_n, out_hiz, bat_sel, bat_en, acc_grant;
    logic [2:0] state_code;

    always #10 clk = ~clk;

    pfs_supervisor #(.HOLD_TICKS(HOLD)) dut (
        .clk(clk), .rst(rst), .por(por), .lvl_run(lvl_run), .lvl_trip(lvl_trip),
        .lvl_swo(lvl_swo), .tick(tick), .host_ce_n(host_ce_n), .host_we_n(host_we_n),
        .host_oe_n(host_oe_n), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .out_hiz(out_hiz), .bat_sel(bat_sel), .bat_en(bat_en),
        .acc_grant(acc_grant), .state_code(state_code)
    );

    typedef struct {
        logic [2:0] st;
        logic       ben, bsel, grant, mce, mwe, hiz;
        string      st_tag;
        string      gate_tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model state
    int m_st = 0;
    int m_cnt = 0;
    bit m_bat = 0;

    task automatic cmp(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit r, input bit p, input bit run, input bit trip, input bit swo,
                        input bit tk, input bit ce, input bit we, input bit oe);
        exp_t e;
        int nst;
        string tag;
        @(negedge clk);
        rst = r; por = p; lvl_run = run; lvl_trip = trip; lvl_swo = swo;
        tick = tk; host_ce_n = ce; host_we_n = we; host_oe_n = oe;
        nst = m_st;
        tag = "R9";
        if (p) begin
            nst = 0; m_cnt = 0;
        end else if (r) begin
            nst = m_bat ? 1 : 0; m_cnt = 0;
        end else begin
            case (m_st)
                0: begin tag = "R2"; if (trip) nst = 3; end
                1: begin tag = "R6"; if (!swo) nst = 2; else if (trip) nst = 3; end
                2: begin tag = "R4"; if (swo) nst = 1; end
                3: begin
                    tag = trip ? "R7" : "R5";
                    if (!trip) nst = swo ? 1 : 2;
                    else if (m_cnt == HOLD) nst = 4;
                end
                default: begin tag = "R5"; if (!trip) nst = swo ? 1 : 2; end
            endcase
            if (m_st != 3 || !run || !ce) m_cnt = 0;
            else if (tk && m_cnt < HOLD) m_cnt++;
        end
        if (p) m_bat = 0;
        else if (trip) m_bat = 1;
        m_st = nst;
        e.st = 3'(m_st);
        e.ben = m_bat;
        e.bsel = (m_st == 2);
        e.grant = (m_st == 4) && trip;
        e.mce = e.grant ? ce : 1'b1;
        e.mwe = e.grant ? (we | ce) : 1'b1;
        e.hiz = e.grant ? !(!ce && !oe && we) : 1'b1;
        e.st_tag = tag;
        e.gate_tag = !trip ? "R3" : ((m_st == 4) ? "R8" : "R9");
        q.push_back(e);
    endtask

    task automatic hold(input int n, input bit run, input bit trip, input bit swo, input bit tk,
                        input bit ce, input bit we, input bit oe);
        for (int i = 0; i < n; i++) step(0, 0, run, trip, swo, tk, ce, we, oe);
    endtask

    // Monitor: pops one expectation per edge and compares a quarter period later.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (state_code !== e.st) begin
                    errors++;
                    $display("FAIL %s state_code actual=%0d expected=%0d t=%0t",
                             e.st_tag, state_code, e.st, $time);
                end
                cmp("R1", "bat_en", bat_en, e.ben);
                cmp("R4", "bat_sel", bat_sel, e.bsel);
                cmp("R10", "acc_grant", acc_grant, e.grant);
                cmp(e.gate_tag, "mem_ce_n", mem_ce_n, e.mce);
                cmp(e.gate_tag, "mem_we_n", mem_we_n, e.mwe);
                cmp(e.gate_tag, "out_hiz", out_hiz, e.hiz);
            end
        end
    end

    initial begin
        rst = 1; por = 1; lvl_run = 0; lvl_trip = 0; lvl_swo = 0; tick = 0;
        host_ce_n = 1; host_we_n = 1; host_oe_n = 1;
        // reset state (R9, R1)
        step(1, 1, 0, 0, 0, 0, 1, 1, 1);
        step(1, 1, 0, 0, 0, 0, 1, 1, 1);
        step(1, 0, 0, 0, 0, 0, 1, 1, 1);
        // sealed: switchover alone and host activity change nothing (R2)
        hold(3, 0, 0, 1, 1, 0, 0, 1);
        hold(2, 0, 0, 0, 1, 0, 1, 0);
        // cold first power-up with steady ticks (R1, R6 path via sealed, R7)
        hold(HOLD + 3, 1, 1, 1, 1, 1, 1, 1);
        // granted: read, write, deselect, write with OE active (R8)
        hold(2, 1, 1, 1, 1, 0, 1, 0);
        hold(2, 1, 1, 1, 1, 0, 0, 1);
        hold(1, 1, 1, 1, 1, 1, 0, 0);
        hold(1, 1, 1, 1, 1, 0, 0, 0);
        hold(1, 1, 1, 1, 1, 0, 1, 1);
        // below run but above trip keeps access (hysteresis)
        hold(2, 0, 1, 1, 1, 0, 1, 0);
        // brown-out during a write: immediate shut (R3), then protected (R5)
        hold(3, 0, 0, 1, 1, 0, 0, 1);
        // return; host CE pulse restarts count (R6, R7)
        hold(3, 1, 1, 1, 1, 1, 1, 1);
        hold(1, 1, 1, 1, 1, 0, 1, 1);
        hold(HOLD + 2, 1, 1, 1, 1, 1, 1, 1);
        // full loss in one cycle: straight to backup (R5, R4)
        hold(4, 0, 0, 0, 1, 0, 0, 0);
        // switchover back: protected, then recovery with sparse ticks
        hold(2, 0, 0, 1, 1, 1, 1, 1);
        for (int i = 0; i < 4; i++) begin
            step(0, 0, 1, 1, 1, 1, 1, 1, 1);
            step(0, 0, 1, 1, 1, 0, 1, 1, 1);
        end
        // dip below run only: count restarts, state stays recovery (R7)
        hold(2, 0, 1, 1, 1, 1, 1, 1);
        // trip glitch during recovery: back to protected (R5)
        hold(1, 1, 0, 1, 1, 1, 1, 1);
        hold(HOLD + 3, 1, 1, 1, 1, 1, 1, 1);
        hold(1, 1, 1, 1, 1, 0, 1, 0);
        // functional reset keeps the arming latch (R1, R9)
        step(1, 0, 1, 1, 1, 1, 1, 1, 1);
        hold(HOLD + 3, 1, 1, 1, 1, 1, 1, 1);
        // power-on reset clears it; supply low keeps it sealed (R1, R2)
        step(0, 1, 0, 0, 0, 0, 1, 1, 1);
        step(1, 0, 0, 0, 0, 0, 1, 1, 1);
        hold(3, 0, 0, 1, 1, 0, 0, 1);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule